// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Result Register Pair

This block performs 32-bit integer multiplication and division over many clock cycles. Its results do not go to the general register file. They land in a private pair of 32-bit registers, HI and LO. A multiply spreads its 64-bit product across the pair. A divide puts the remainder in HI and the quotient in LO. A core issues one command per cycle on a single command port. While an arithmetic command runs, `busy_o` is high. The core can also copy either register out, or load either register from an operand. A copy-out that arrives while the unit is busy is refused through `stall_o`, and the core retries it.

Signed and unsigned forms of both operations are supported. Multiplication adds and shifts one multiplier bit per cycle. Division is restoring and produces one quotient bit per cycle. For signed commands, the unit works on operand magnitudes and fixes the result signs on the final cycle. A zero divisor is not trapped. It runs for the usual number of cycles and leaves a defined pattern in the pair.

Top module: `mdu_hilo`

## Requirements
- R1: A command is accepted when `cmd_valid_i` is high at a rising clock edge. `cmd_op_i` is decoded as: 0 = signed multiply, 1 = unsigned multiply, 2 = signed divide, 3 = unsigned divide, 4 = read HI, 5 = read LO, 6 = write HI, 7 = write LO. Operand A is `opa_i` (multiplicand, dividend, or write value). Operand B is `opb_i` (multiplier or divisor).
- R2: After reset, HI and LO read zero and `busy_o` and `rd_valid_o` are low.
- R3: An arithmetic command accepted while idle drives `busy_o` high from the next cycle for exactly 32 cycles. HI and LO take the new result in the first cycle in which `busy_o` is low again.
- R4: An unsigned multiply leaves bits 63..32 of the 64-bit product in HI and bits 31..0 in LO.
- R5: A signed multiply leaves the full two's-complement 64-bit product in HI:LO.
- R6: An unsigned divide leaves the quotient in LO and the remainder in HI.
- R7: A signed divide truncates the quotient toward zero, and the remainder takes the sign of the dividend. The most negative dividend divided by -1 gives quotient 0x80000000 and remainder 0.
- R8: A divide by zero, signed or unsigned, takes the normal 32 cycles and leaves LO = 0xFFFFFFFF and HI = the dividend.
- R9: A read of HI or LO accepted while idle sets `rd_valid_o` for one cycle on the next cycle, with the register value on `rd_data_o`. `stall_o` stays low.
- R10: A read issued while busy raises `stall_o` in the same cycle and produces no `rd_valid_o`. A read issued after completion returns the new result.
- R11: A write of HI or LO accepted while idle loads `opa_i` into that register on the next cycle and leaves the other register unchanged.
- R12: While busy, write commands and further arithmetic commands are ignored. HI and LO do not change until completion, the running operation's length is unchanged, and its result is the one that lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 3 | Command code (see R1) |
| opa_i | input | 32 | Operand A: multiplicand, dividend or write value |
| opb_i | input | 32 | Operand B: multiplier or divisor |
| busy_o | output | 1 | Arithmetic operation in progress |
| stall_o | output | 1 | Read refused this cycle because the unit is busy |
| rd_valid_o | output | 1 | Read response valid |
| rd_data_o | output | 32 | Read response data |
| hi_o | output | 32 | Current HI register |
| lo_o | output | 32 | Current LO register |

## Verification
The hardest case to reach is the window inside a running operation. There, a read must stall, and writes and a second start must leave no trace on the pair or on the run length. The stimulus starts a multiply. On the following cycles it issues a read, a write of HI and a new multiply while `busy_o` is still high. It then counts the remaining busy cycles, compares the landed result with the first operation's expected value, and reads HI back. Signed corner operands, such as the most negative value multiplied by itself or divided by -1, and signed and unsigned zero divisors, cover the sign-fixing paths.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    localparam int unsigned MDU_XLEN  = 32;
    localparam int unsigned MDU_DW    = 2 * MDU_XLEN;
    localparam int unsigned MDU_CNT_W = $clog2(MDU_XLEN);

    typedef logic [MDU_XLEN-1:0] word_t;
    typedef logic [MDU_DW-1:0]   dword_t;

    typedef enum logic [2:0] {
        OP_MULS = 3'd0,
        OP_MULU = 3'd1,
        OP_DIVS = 3'd2,
        OP_DIVU = 3'd3,
        OP_RDHI = 3'd4,
        OP_RDLO = 3'd5,
        OP_WRHI = 3'd6,
        OP_WRLO = 3'd7
    } mdu_op_e;

    typedef struct packed {
        logic                 busy;
        logic                 is_div;
        logic                 neg_res;   // negate product / quotient at the end
        logic                 neg_rem;   // negate remainder at the end
        logic                 div_zero;
        logic [MDU_CNT_W-1:0] count;
        word_t                opnd;      // multiplicand or divisor magnitude
        dword_t               work;      // product or {remainder, quotient}
        word_t                hi;
        word_t                lo;
        logic                 rd_valid;
        word_t                rd_data;
    } mdu_state_t;

    function automatic logic op_is_read(mdu_op_e op);
        return (op == OP_RDHI) || (op == OP_RDLO);
    endfunction

endpackage

// File: rtl/mdu_abs.sv
// Magnitude of an operand, taken only in signed mode.
module mdu_abs #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] val_i,
    input  logic         signed_i,
    output logic [W-1:0] mag_o,
    output logic         neg_o
);
    assign neg_o = signed_i & val_i[W-1];
    assign mag_o = neg_o ? (~val_i + 1'b1) : val_i;
endmodule

// File: rtl/mdu_mul_step.sv
// One shift-add iteration: low half holds the remaining multiplier bits,
// high half the partial product.
module mdu_mul_step #(
    parameter int unsigned W = 32
) (
    input  logic [2*W-1:0] acc_i,
    input  logic [W-1:0]   mcand_i,
    output logic [2*W-1:0] acc_o
);
    logic [W:0] sum;

    assign sum   = {1'b0, acc_i[2*W-1:W]} + (acc_i[0] ? {1'b0, mcand_i} : '0);
    assign acc_o = {sum, acc_i[W-1:1]};
endmodule

// File: rtl/mdu_div_step.sv
// One restoring-division iteration on {remainder, dividend/quotient}.
module mdu_div_step #(
    parameter int unsigned W = 32
) (
    input  logic [2*W-1:0] acc_i,
    input  logic [W-1:0]   divisor_i,
    output logic [2*W-1:0] acc_o
);
    logic [W:0] shifted;
    logic [W:0] trial;

    assign shifted = {acc_i[2*W-1:W], acc_i[W-1]};
    assign trial   = shifted - {1'b0, divisor_i};

    always_comb begin
        if (!trial[W]) begin
            acc_o = {trial[W-1:0], acc_i[W-2:0], 1'b1};
        end else begin
            acc_o = {shifted[W-1:0], acc_i[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo
    import mdu_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        cmd_valid_i,
    input  logic [2:0]  cmd_op_i,
    input  logic [31:0] opa_i,
    input  logic [31:0] opb_i,
    output logic        busy_o,
    output logic        stall_o,
    output logic        rd_valid_o,
    output logic [31:0] rd_data_o,
    output logic [31:0] hi_o,
    output logic [31:0] lo_o
);
    localparam int unsigned NOPND = 2;
    localparam logic [MDU_CNT_W-1:0] LAST_STEP = MDU_CNT_W'(MDU_XLEN - 1);

    mdu_state_t q, d;
    mdu_op_e    op;
    logic       signed_op;

    word_t opnd_in [NOPND];
    word_t mag     [NOPND];
    logic  neg     [NOPND];

    dword_t mul_nxt, div_nxt, prod_fix;
    word_t  quo_fix, rem_fix;

    assign op         = mdu_op_e'(cmd_op_i);
    assign signed_op  = (op == OP_MULS) || (op == OP_DIVS);
    assign opnd_in[0] = opa_i;
    assign opnd_in[1] = opb_i;

    for (genvar g = 0; g < NOPND; g++) begin : g_abs
        mdu_abs #(.W(MDU_XLEN)) u_abs (
            .val_i    (opnd_in[g]),
            .signed_i (signed_op),
            .mag_o    (mag[g]),
            .neg_o    (neg[g])
        );
    end

    mdu_mul_step #(.W(MDU_XLEN)) u_mul (
        .acc_i   (q.work),
        .mcand_i (q.opnd),
        .acc_o   (mul_nxt)
    );

    mdu_div_step #(.W(MDU_XLEN)) u_div (
        .acc_i     (q.work),
        .divisor_i (q.opnd),
        .acc_o     (div_nxt)
    );

    // Sign correction applied on the last iteration.
    assign prod_fix = q.neg_res ? (~mul_nxt + 1'b1) : mul_nxt;
    assign quo_fix  = q.div_zero ? '1 :
                      (q.neg_res ? (~div_nxt[MDU_XLEN-1:0] + 1'b1) : div_nxt[MDU_XLEN-1:0]);
    assign rem_fix  = q.neg_rem ? (~div_nxt[MDU_DW-1:MDU_XLEN] + 1'b1)
                                : div_nxt[MDU_DW-1:MDU_XLEN];

    always_comb begin
        d          = q;
        d.rd_valid = 1'b0;
        if (q.busy) begin
            d.count = q.count + 1'b1;
            d.work  = q.is_div ? div_nxt : mul_nxt;
            if (q.count == LAST_STEP) begin
                d.busy = 1'b0;
                if (q.is_div) begin
                    d.hi = rem_fix;
                    d.lo = quo_fix;
                end else begin
                    d.hi = prod_fix[MDU_DW-1:MDU_XLEN];
                    d.lo = prod_fix[MDU_XLEN-1:0];
                end
            end
        end else if (cmd_valid_i) begin
            unique case (op)
                OP_MULS, OP_MULU: begin
                    d.busy     = 1'b1;
                    d.is_div   = 1'b0;
                    d.count    = '0;
                    d.opnd     = mag[0];
                    d.work     = {{MDU_XLEN{1'b0}}, mag[1]};
                    d.neg_res  = neg[0] ^ neg[1];
                    d.neg_rem  = 1'b0;
                    d.div_zero = 1'b0;
                end
                OP_DIVS, OP_DIVU: begin
                    d.busy     = 1'b1;
                    d.is_div   = 1'b1;
                    d.count    = '0;
                    d.opnd     = mag[1];
                    d.work     = {{MDU_XLEN{1'b0}}, mag[0]};
                    d.neg_res  = neg[0] ^ neg[1];
                    d.neg_rem  = neg[0];
                    d.div_zero = (opb_i == '0);
                end
                OP_RDHI: begin
                    d.rd_valid = 1'b1;
                    d.rd_data  = q.hi;
                end
                OP_RDLO: begin
                    d.rd_valid = 1'b1;
                    d.rd_data  = q.lo;
                end
                OP_WRHI: d.hi = opa_i;
                OP_WRLO: d.lo = opa_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o     = q.busy;
    assign stall_o    = cmd_valid_i && q.busy && op_is_read(op);
    assign rd_valid_o = q.rd_valid;
    assign rd_data_o  = q.rd_data;
    assign hi_o       = q.hi;
    assign lo_o       = q.lo;

endmodule

// File: rtl/mdu_hilo_chk.sv
module mdu_hilo_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            cmd_valid_i,
    input logic [2:0]      cmd_op_i,
    input logic [XLEN-1:0] opa_i,
    input logic            busy_o,
    input logic            stall_o,
    input logic            rd_valid_o,
    input logic [XLEN-1:0] hi_o,
    input logic [XLEN-1:0] lo_o
);
    localparam int unsigned RUN_W = $clog2(XLEN + 1) + 1;

    logic [RUN_W-1:0] run_cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_cnt <= '0;
        end else if (busy_o) begin
            run_cnt <= run_cnt + 1'b1;
        end else begin
            run_cnt <= '0;
        end
    end

    assert_start_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && !busy_o && cmd_op_i < 3'd4) |=> busy_o);

    assert_busy_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> (run_cnt == RUN_W'(XLEN)));

    assert_read_resp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_o |-> $past(cmd_valid_i && !busy_o && (cmd_op_i == 3'd4 || cmd_op_i == 3'd5)));

    assert_stall_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o |-> (busy_o && cmd_valid_i));

    assert_write_hi_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && !busy_o && cmd_op_i == 3'd6) |=> (hi_o == $past(opa_i) && $stable(lo_o)));

    assert_hold_pair_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o)) |-> ($stable(hi_o) && $stable(lo_o)));

endmodule

bind mdu_hilo mdu_hilo_chk #(.XLEN(32)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .opa_i       (opa_i),
    .busy_o      (busy_o),
    .stall_o     (stall_o),
    .rd_valid_o  (rd_valid_o),
    .hi_o        (hi_o),
    .lo_o        (lo_o)
);

// File: tb/mdu_hilo_tb_top.sv
module mdu_hilo_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        busy, stall, rd_valid;
    logic [31:0] rd_data, hi, lo;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [63:0] val;
        string       req;
        bit          is_read;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;   // 50 MHz

    mdu_hilo dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cmd_valid_i (cmd_valid),
        .cmd_op_i    (cmd_op),
        .opa_i       (opa),
        .opb_i       (opb),
        .busy_o      (busy),
        .stall_o     (stall),
        .rd_valid_o  (rd_valid),
        .rd_data_o   (rd_data),
        .hi_o        (hi),
        .lo_o        (lo)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Reference model: returns {HI, LO}
    function automatic logic [63:0] model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        logic signed [63:0] sa, sb, sq, sr;
        logic [63:0] ua, ub;
        sa = {{32{a[31]}}, a};
        sb = {{32{b[31]}}, b};
        ua = {32'd0, a};
        ub = {32'd0, b};
        case (op)
            3'd0: return sa * sb;
            3'd1: return ua * ub;
            3'd2: begin
                if (b == 0) return {a, 32'hFFFF_FFFF};
                sq = sa / sb;
                sr = sa % sb;
                return {sr[31:0], sq[31:0]};
            end
            default: begin
                if (b == 0) return {a, 32'hFFFF_FFFF};
                return {(ua % ub), 32'd0} | {32'd0, (ua / ub)};
            end
        endcase
    endfunction

    task automatic drive(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        opa       = a;
        opb       = b;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic run_arith(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b, input string req);
        int cyc;
        exp_t e;
        e.val = model(op, a, b);
        e.req = req;
        e.is_read = 1'b0;
        exp_q.push_back(e);
        drive(op, a, b);
        cyc = 0;
        while (busy && cyc < 100) begin
            cyc++;
            @(negedge clk);
        end
        check(cyc == 32, "R3 busy length", 64'(cyc), 64'd32);
    endtask

    task automatic do_read(input logic [2:0] op, input logic [31:0] expv, input string req);
        exp_t e;
        e.val = {32'd0, expv};
        e.req = req;
        e.is_read = 1'b1;
        exp_q.push_back(e);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        #1;
        check(stall == 1'b0, "R9 no stall when idle", {63'd0, stall}, 64'd0);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Monitor / scoreboard
    initial begin
        bit prev_busy = 1'b0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_busy && !busy) begin
                    if (exp_q.size() == 0 || exp_q[0].is_read) begin
                        check(1'b0, "R3 unexpected completion", {hi, lo}, 64'd0);
                    end else begin
                        e = exp_q.pop_front();
                        check({hi, lo} == e.val, e.req, {hi, lo}, e.val);
                    end
                end
                if (rd_valid) begin
                    if (exp_q.size() == 0 || !exp_q[0].is_read) begin
                        check(1'b0, "R9 unexpected read response", {32'd0, rd_data}, 64'd0);
                    end else begin
                        e = exp_q.pop_front();
                        check({32'd0, rd_data} == e.val, e.req, {32'd0, rd_data}, e.val);
                    end
                end
            end
            prev_busy = busy;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog expired: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] first;
        int rem_cyc;
        exp_t e;

        repeat (3) @(negedge clk);
        // R2: reset state
        check(hi == 0 && lo == 0, "R2 reset pair", {hi, lo}, 64'd0);
        check(busy == 0 && rd_valid == 0, "R2 reset flags", {62'd0, busy, rd_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 / R1: unsigned multiply
        run_arith(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 umul max");
        run_arith(3'd1, 32'h0001_2345, 32'h0000_0100, "R4 umul small");
        // R5: signed multiply
        run_arith(3'd0, 32'hFFFF_FFFD, 32'd7, "R5 smul neg*pos");
        run_arith(3'd0, 32'hFFFF_FFFB, 32'hFFFF_FFFA, "R5 smul neg*neg");
        run_arith(3'd0, 32'h8000_0000, 32'h8000_0000, "R5 smul min*min");
        // R6: unsigned divide
        run_arith(3'd3, 32'd100, 32'd7, "R6 udiv 100/7");
        run_arith(3'd3, 32'hFFFF_FFFF, 32'h10, "R6 udiv max/16");
        run_arith(3'd3, 32'd5, 32'hFFFF_FFF0, "R6 udiv small/large");
        // R7: signed divide
        run_arith(3'd2, 32'hFFFF_FFF9, 32'd2, "R7 sdiv -7/2");
        run_arith(3'd2, 32'd7, 32'hFFFF_FFFE, "R7 sdiv 7/-2");
        run_arith(3'd2, 32'h8000_0000, 32'hFFFF_FFFF, "R7 sdiv min/-1");
        // R8: divide by zero
        run_arith(3'd3, 32'd1234, 32'd0, "R8 udiv by zero");
        run_arith(3'd2, 32'hFFFF_FFFB, 32'd0, "R8 sdiv by zero");

        // R9: reads after completion (HI=-5, LO=all ones)
        do_read(3'd4, 32'hFFFF_FFFB, "R9 read HI");
        do_read(3'd5, 32'hFFFF_FFFF, "R9 read LO");

        // R11: writes while idle
        drive(3'd6, 32'hDEAD_BEEF, 32'd0);
        check(hi == 32'hDEAD_BEEF && lo == 32'hFFFF_FFFF, "R11 write HI", {hi, lo}, {32'hDEAD_BEEF, 32'hFFFF_FFFF});
        drive(3'd7, 32'h0BAD_F00D, 32'd0);
        check(hi == 32'hDEAD_BEEF && lo == 32'h0BAD_F00D, "R11 write LO", {hi, lo}, {32'hDEAD_BEEF, 32'h0BAD_F00D});
        do_read(3'd5, 32'h0BAD_F00D, "R11 read back LO");

        // R10 / R12: activity while busy
        first   = model(3'd1, 32'h0000_1234, 32'h0000_5678);
        e.val   = first;
        e.req   = "R12 result survives busy-time commands";
        e.is_read = 1'b0;
        exp_q.push_back(e);
        drive(3'd1, 32'h0000_1234, 32'h0000_5678);
        cmd_valid = 1'b1;                  // read HI while busy
        cmd_op    = 3'd4;
        #1;
        check(stall == 1'b1, "R10 stall on busy read", {63'd0, stall}, 64'd1);
        @(negedge clk);
        check(rd_valid == 1'b0, "R10 no response to stalled read", {63'd0, rd_valid}, 64'd0);
        cmd_op = 3'd6;                     // write HI while busy
        opa    = 32'h5555_AAAA;
        @(negedge clk);
        check(hi == 32'hDEAD_BEEF, "R12 write ignored while busy", {32'd0, hi}, {32'd0, 32'hDEAD_BEEF});
        cmd_op = 3'd1;                     // new multiply while busy
        opa    = 32'd3;
        opb    = 32'd3;
        @(negedge clk);
        cmd_valid = 1'b0;
        rem_cyc = 0;
        while (busy && rem_cyc < 100) begin
            rem_cyc++;
            @(negedge clk);
        end
        check(rem_cyc == 29, "R12 run length unchanged", 64'(rem_cyc), 64'd29);
        do_read(3'd4, first[63:32], "R10 read after completion");
        @(negedge clk);
        check(busy == 1'b0, "R12 ignored start did not run", {63'd0, busy}, 64'd0);
        check(exp_q.size() == 0, "R1 scoreboard drained", 64'(exp_q.size()), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule